// File: doc/BRIEF.md
# Serial Register-Access Target with Start Snapshot

This block is a two-wire serial bus target. It gives a bus master read and write access to a small register file, sixteen entries by default. It works from a fast system clock and oversamples the raw SCL and SDA lines. It finds bus conditions and bit edges from the synchronized samples. It answers acknowledge slots and sends read data through an open-drain pull-down enable.

An internal register pointer picks the entry. On a write, the first byte after the device address loads the pointer, and every later byte is written there as a one-cycle strobe that carries address and data. On a read, the byte at the pointer goes out MSB first. The pointer advances after every byte on both paths and wraps at the top of the space.

Every START, repeated or not, also raises a one-cycle snapshot strobe. The surrounding logic uses it to copy the running time counters into a shadow set. Reads are then served from that shadow set, so the copy stays coherent while the counters keep running.

Top module: `i2c_reg_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1010001, with bit 0 as the direction (0 write, 1 read). It pulls SDA low through the whole ninth clock.
- R2: With any other address the block gives no acknowledge. It drives SDA for no later bit and raises no write strobe until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The pull-down enable changes only while SCL is low.
- R4: In a write, the first byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and raises `wr_en` for one cycle with `wr_addr` equal to the pointer and `wr_data` equal to the byte; the pointer then increments.
- R5: The pointer wraps from the top entry (0Fh by default) to 00h, for writes and for reads.
- R6: Every START, including a repeated START, raises `snap` for exactly one cycle.
- R7: In a read, each byte is `rd_data` at the pointer, sent MSB first. The pointer increments after each byte, and a master acknowledge makes the next byte follow.
- R8: A read with no pointer byte written first continues from the pointer left by the previous transfer.
- R9: After a master no-acknowledge, SDA is released and stays released for further SCL pulses until START or STOP.
- R10: A repeated START ends the current transfer, even in the middle of a byte, without writing, and begins a new address phase.
- R11: Out of reset, `sda_oe`, `wr_en` and `snap` are low and the pointer (`rd_addr`) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| snap | output | 1 | One-cycle strobe on each START |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | AW | Register index for the write |
| wr_data | output | DW | Byte to write |
| rd_addr | output | AW | Current pointer, selects read data |
| rd_data | input | DW | Shadow/register value at `rd_addr` |

## Verification
Each line passes through two synchronizer flops and one edge flop. The registered outputs (`snap`, `wr_en`, `sda_oe`) therefore follow the bus event that causes them by about three system clocks. The bench holds each SCL phase for 25 clocks and samples SDA in the middle of the SCL high phase. Every acknowledge and data bit is read well after it has settled and long before the next SCL edge. Strobes are counted and captured at every clock edge by a monitor. The transaction tasks check those counts after each transfer completes, so no check depends on the exact strobe cycle.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1010001,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          snap,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [2:0]    scl_s, sda_s;
  st_t           st;
  kind_t         kind;
  logic          rw, mack;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_rise  = scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] & scl_s[2];
  wire start_det = scl_s[1] & scl_s[2] & ~sda_s[1] & sda_s[2];
  wire stop_det  = scl_s[1] & scl_s[2] & sda_s[1] & ~sda_s[2];

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      kind    <= K_ADDR;
      rw      <= 1'b0;
      mack    <= 1'b0;
      bcnt    <= '0;
      sh      <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      snap    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      snap  <= start_det;
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bcnt < FULL) begin
              sh   <= {sh[DW-2:0], sda_s[1]};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == FULL) begin
              bcnt <= '0;
              case (kind)
                K_ADDR:
                  if (sh[DW-1:1] == DEV_ADDR) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    st     <= S_RACK;
                  end else begin
                    st <= S_IDLE;
                  end
                K_PTR: begin
                  ptr    <= sh[AW-1:0];
                  sda_oe <= 1'b1;
                  st     <= S_RACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 1'b1;
                  sda_oe  <= 1'b1;
                  st      <= S_RACK;
                end
              endcase
            end
          end
          S_RACK:
            if (scl_fall) begin
              if (kind == K_ADDR && rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          S_TX:
            if (scl_fall) begin
              if (bcnt == LAST) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                bcnt   <= '0;
                st     <= S_MACK;
              end else begin
                sh     <= {sh[DW-2:0], 1'b0};
                sda_oe <= ~sh[DW-2];
                bcnt   <= bcnt + 1'b1;
              end
            end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_s[1];
            if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assert_snap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !snap);

  assert_write_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en && $stable(wr_addr));

  assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_sda_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s[1]) || $past(start_det) || $past(stop_det)));

  assert_ack_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK) |-> sda_oe);
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int H = 25;
  localparam logic [11:0] VEC [0:5] = '{12'h259, 12'h5A0, 12'h0FF, 12'hF3C, 12'h700, 12'hA81};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, snap, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] regs [16];
  wire        sda = sda_m & ~sda_oe;

  int errors = 0, checks = 0;
  int wr_cnt = 0, snap_cnt = 0, drive_cnt = 0, bad_change = 0;
  logic [3:0] last_a = '0;
  logic [7:0] last_d = '0;
  logic       prev_oe = 1'b0, prev_scl = 1'b1;

  always #2.5 clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .snap(snap), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign rd_data = regs[rd_addr];

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'(i * 17);
    end else begin
      if (wr_en) begin
        regs[wr_addr] <= wr_data;
        last_a <= wr_addr;
        last_d <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      if (snap) snap_cnt <= snap_cnt + 1;
      if (sda_oe) drive_cnt <= drive_cnt + 1;
      if (sda_oe != prev_oe && scl && prev_scl) bad_change <= bad_change + 1;
      prev_oe  <= sda_oe;
      prev_scl <= scl;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(H); scl = 1'b1; hold(H); sda_m = 1'b0; hold(H); scl = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(H); scl = 1'b1; hold(H); sda_m = 1'b1; hold(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(H); scl = 1'b1; hold(H / 2);
    ack = ~sda;
    hold(H - H / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl = 1'b1; hold(H / 2);
      b[i] = sda;
      hold(H - H / 2); scl = 1'b0;
    end
    sda_m = ~give_ack; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    int w0, s0, d0;
    hold(5);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 wr_en", wr_en, 0);
    chk("R11 snap", snap, 0);
    chk("R11 pointer", rd_addr, 0);
    rst_n = 1'b1;
    hold(5);

    for (int v = 0; v < 6; v++) begin
      w0 = wr_cnt; s0 = snap_cnt;
      bus_start();
      send_byte(8'hA2, ack); chk("R1 write addr ack", ack, 1);
      send_byte({4'h0, VEC[v][11:8]}, ack); chk("R4 pointer ack", ack, 1);
      send_byte(VEC[v][7:0], ack); chk("R4 data ack", ack, 1);
      bus_stop();
      chk("R4 one strobe", wr_cnt - w0, 1);
      chk("R4 wr_addr", last_a, VEC[v][11:8]);
      chk("R4 wr_data", last_d, VEC[v][7:0]);
      bus_start();
      send_byte(8'hA2, ack);
      send_byte({4'h0, VEC[v][11:8]}, ack);
      bus_start();
      send_byte(8'hA3, ack); chk("R1 read addr ack", ack, 1);
      recv_byte(1'b0, rb); chk("R7 read data", rb, VEC[v][7:0]);
      bus_stop();
      chk("R6 snap per START", snap_cnt - s0, 3);
    end

    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h0E, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop();
    chk("R5 wrap write addr", last_a, 4'h0);
    chk("R5 wrap write data", regs[0], 8'h33);
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h0E, ack);
    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(1'b1, rb); chk("R7 burst byte0", rb, 8'h11);
    recv_byte(1'b1, rb); chk("R5 burst byte1", rb, 8'h22);
    recv_byte(1'b0, rb); chk("R5 wrap read", rb, 8'h33);
    bus_stop();
    chk("R5 pointer after wrap", rd_addr, 4'h1);

    bus_start();
    send_byte(8'hA3, ack); chk("R8 addr ack", ack, 1);
    recv_byte(1'b0, rb); chk("R8 resume read", rb, regs[1]);
    bus_stop();

    w0 = wr_cnt; d0 = drive_cnt;
    bus_start();
    send_byte(8'hA4, ack); chk("R2 no ack", ack, 0);
    send_byte(8'h05, ack); chk("R2 ignored byte", ack, 0);
    send_byte(8'h77, ack);
    bus_stop();
    chk("R2 no write", wr_cnt - w0, 0);
    chk("R2 no drive", drive_cnt - d0, 0);

    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(1'b0, rb);
    d0 = drive_cnt;
    recv_byte(1'b0, rb); chk("R9 released after nack", rb, 8'hFF);
    chk("R9 no drive", drive_cnt - d0, 0);
    bus_stop();

    w0 = wr_cnt;
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h03, ack);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hA3, ack); chk("R10 new addr phase", ack, 1);
    recv_byte(1'b0, rb); chk("R10 read after restart", rb, regs[3]);
    bus_stop();
    chk("R10 no write", wr_cnt - w0, 0);

    chk("R3 sda change only with scl low", bad_change, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule